// File: doc/BRIEF.md
# Four-Channel Synchronously Updated Pulse-Width Modulator

This block drives four pulse-width modulated outputs from one clock. Each channel runs its own free counter and compares it against a period count and an active-time count. Software programs the channels through a small 32-bit register bus with byte addresses, a write strobe, write data and registered read data. All waveform settings (period, active time, polarity and enable) are written into staging registers first and do nothing until software requests an update.

An update request arms every channel at once. Each running channel then copies its staged settings into its working copy at the end of its own current period, so no output ever shows a shortened or stretched cycle. A channel that is not running has no period to finish, and it copies its staged settings on the next clock edge. The waveform is trailing-edge mark/space: the output is active for the first part of each period and inactive for the rest.

Top module: `pwm_sync_bank`

## Requirements
- R1: After reset every output is low, every channel control register reads 0x00000101, and the global control, period, active-time and phase registers read 0.
- R2: Register map: global control at 0x00; for channel n, control at 0x14+0x10·n, period at 0x18+0x10·n, phase at 0x1C+0x10·n and active time at 0x20+0x10·n. A write lands on the clock edge that samples the strobe. Read data appears on the edge after the address is presented and shows staging values. Period and active time hold the low 16 bits, and their upper bits read 0. Channel control keeps bits 8, 3 and 1:0, and its other bits read 0. Unmapped addresses read 0.
- R3: Writes to staging registers, including the enable bits 3:0 of global control, leave every output unchanged until an update is requested.
- R4: Writing global control with bit 31 set arms all channels. A running channel applies the staged values at the end of its current period, never partway through it.
- R5: A channel that is not running applies staged values on the clock edge after the update request.
- R6: With period P>0 and active time D<P, an enabled channel repeats a P-cycle waveform that is active for D cycles.
- R7: D≥P gives a constant active output, D=0 gives a constant inactive output, and P=0 holds the output inactive.
- R8: Control bit 3 inverts the output. A disabled channel drives its inactive level: low for normal polarity and high for inverted polarity.
- R9: Global control bit 31 reads 1 while any channel is still armed, and clears by itself once all channels have applied their values.
- R10: The phase registers and the mode field (control bits 1:0) are stored and read back, but they do not change the waveform.
- R11: Channels run independently, each with its own period, so that different periods coexist on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the address presented one cycle earlier |
| pwm_out | output | 4 | Channel outputs, bit n for channel n |

## Verification
The assertions assume that reset is held low for at least one clock edge, and that the bus is quiet while reset is asserted. They also assume that `bus_addr` and `bus_wdata` are stable and known whenever `bus_wr` is high. The bench meets these assumptions by changing every input only on falling edges and by keeping the strobe low through reset. The waveform checks count active samples over whole multiples of the period, so they do not depend on counter phase. The one mid-period check first locks onto a rising output edge, which marks counter value 0.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam logic [7:0] GLB_ADDR   = 8'h00;
  localparam logic [7:0] CH_BASE    = 8'h14;
  localparam int         CH_STRIDE  = 16;
  localparam int         UPD_BIT    = 31;
  localparam int         POL_BIT    = 3;
  localparam int         MASK_BIT   = 8;
  localparam logic [1:0] MODE_RESET = 2'd1;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_RANGE = 2'd1,
    SEL_PHASE = 2'd2,
    SEL_DUTY  = 2'd3
  } chreg_e;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [7:0]                    bus_addr,
  input  logic                          bus_wr,
  input  logic [31:0]                   bus_wdata,
  output logic [31:0]                   bus_rdata,
  input  logic [NUM_CH-1:0]             pend_i,
  output logic                          upd_req,
  output logic [NUM_CH-1:0]             stg_en,
  output logic [NUM_CH-1:0]             stg_pol,
  output logic [NUM_CH-1:0][CNT_W-1:0]  stg_range,
  output logic [NUM_CH-1:0][CNT_W-1:0]  stg_duty
);
  localparam int IDX_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam int CH_SPAN = NUM_CH * CH_STRIDE;

  logic [NUM_CH-1:0]        mask_q;
  logic [NUM_CH-1:0][1:0]   mode_q;
  logic [NUM_CH-1:0][31:0]  phase_q;

  logic [7:0]   off;
  logic         in_ch, glb_hit;
  logic [IDX_W-1:0] ch_idx;
  chreg_e       sel;
  logic [31:0]  rd_mux;

  assign off     = bus_addr - CH_BASE;
  assign in_ch   = (bus_addr >= CH_BASE) && (int'(off) < CH_SPAN) && (bus_addr[1:0] == 2'b00);
  assign glb_hit = (bus_addr == GLB_ADDR);
  assign ch_idx  = off[4 +: IDX_W];
  assign sel     = chreg_e'(off[3:2]);
  assign upd_req = bus_wr && glb_hit && bus_wdata[UPD_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stg_en    <= '0;
      stg_pol   <= '0;
      mask_q    <= '1;
      mode_q    <= {NUM_CH{MODE_RESET}};
      stg_range <= '0;
      stg_duty  <= '0;
      phase_q   <= '0;
    end else if (bus_wr) begin
      if (glb_hit) stg_en <= bus_wdata[NUM_CH-1:0];
      for (int c = 0; c < NUM_CH; c++) begin
        if (in_ch && (int'(ch_idx) == c)) begin
          case (sel)
            SEL_CTRL: begin
              mask_q[c]  <= bus_wdata[MASK_BIT];
              stg_pol[c] <= bus_wdata[POL_BIT];
              mode_q[c]  <= bus_wdata[1:0];
            end
            SEL_RANGE: stg_range[c] <= bus_wdata[CNT_W-1:0];
            SEL_PHASE: phase_q[c]   <= bus_wdata;
            default:   stg_duty[c]  <= bus_wdata[CNT_W-1:0];
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (glb_hit) begin
      rd_mux[UPD_BIT]     = |pend_i;
      rd_mux[NUM_CH-1:0]  = stg_en;
    end
    for (int c = 0; c < NUM_CH; c++) begin
      if (in_ch && (int'(ch_idx) == c)) begin
        case (sel)
          SEL_CTRL: begin
            rd_mux[MASK_BIT] = mask_q[c];
            rd_mux[POL_BIT]  = stg_pol[c];
            rd_mux[1:0]      = mode_q[c];
          end
          SEL_RANGE: rd_mux[CNT_W-1:0] = stg_range[c];
          SEL_PHASE: rd_mux = phase_q[c];
          default:   rd_mux[CNT_W-1:0] = stg_duty[c];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_mux;
  end

  // R9
  upd_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_req |=> (&pend_i));
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_req,
  input  logic             stg_en,
  input  logic             stg_pol,
  input  logic [CNT_W-1:0] stg_range,
  input  logic [CNT_W-1:0] stg_duty,
  output logic             pend_o,
  output logic             pwm_o
);
  logic             act_en, act_pol;
  logic [CNT_W-1:0] act_range, act_duty, cnt;
  logic             eop, active;

  // End of period: a stopped or zero-period channel is always at a boundary.
  assign eop    = !act_en || (act_range == '0) || (cnt >= act_range - CNT_W'(1));
  assign active = act_en && (act_range != '0) && (cnt < act_duty);
  assign pwm_o  = active ^ act_pol;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      pend_o    <= 1'b0;
      act_en    <= 1'b0;
      act_pol   <= 1'b0;
      act_range <= '0;
      act_duty  <= '0;
    end else begin
      cnt <= eop ? '0 : cnt + CNT_W'(1);
      if (eop && pend_o) begin
        act_en    <= stg_en;
        act_pol   <= stg_pol;
        act_range <= stg_range;
        act_duty  <= stg_duty;
      end
      if (upd_req)  pend_o <= 1'b1;
      else if (eop) pend_o <= 1'b0;
    end
  end

  // R4
  mid_period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(eop) |-> ($stable(act_duty) && $stable(act_range) && $stable(act_en) && $stable(act_pol)));

  // R3
  unarmed_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_o |=> ($stable(act_duty) && $stable(act_range) && $stable(act_en) && $stable(act_pol)));

  // R5
  idle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !act_en && !upd_req) |=> !pend_o);

  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_en && act_range != '0) |-> (cnt < act_range));

  // R7
  zero_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act_range == '0) |-> (pwm_o == act_pol));
endmodule

// File: rtl/pwm_sync_bank.sv
module pwm_sync_bank #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);
  logic                         upd_req;
  logic [NUM_CH-1:0]            pend, stg_en, stg_pol;
  logic [NUM_CH-1:0][CNT_W-1:0] stg_range, stg_duty;

  pwm_regfile #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pend_i(pend),
    .upd_req(upd_req), .stg_en(stg_en), .stg_pol(stg_pol),
    .stg_range(stg_range), .stg_duty(stg_duty)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_chan #(.CNT_W(CNT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .upd_req(upd_req),
      .stg_en(stg_en[g]), .stg_pol(stg_pol[g]),
      .stg_range(stg_range[g]), .stg_duty(stg_duty[g]),
      .pend_o(pend[g]), .pwm_o(pwm_out[g])
    );
  end
endmodule

// File: tb/test_pwm_sync_bank.sv
module test_pwm_sync_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pwm_sync_bank i_pwm_sync_bank (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  function automatic logic [7:0] ca(input int ch, input int sel);
    return 8'(8'h14 + ch * 16 + sel * 4);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    @(posedge clk); @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic count_hi(input int ch, input int n, output int hi);
    hi = 0;
    for (int i = 0; i < n; i++) begin
      hi += int'(pwm_out[ch]);
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 outputs", {28'd0, pwm_out}, 32'h0);
    for (int c = 0; c < 4; c++) begin
      rd(ca(c, 0), d); check("R1 ctrl", d, 32'h101);
    end
    rd(8'h00, d);     check("R1 global", d, 32'h0);
    rd(ca(2, 1), d);  check("R1 period", d, 32'h0);
    rd(ca(1, 2), d);  check("R1 phase", d, 32'h0);
  endtask

  task automatic t_regs;
    logic [31:0] d;
    wr(ca(0, 1), 32'hABCD_1234); rd(ca(0, 1), d); check("R2 period width", d, 32'h0000_1234);
    wr(ca(3, 0), 32'hFFFF_FFFF); rd(ca(3, 0), d); check("R2 ctrl bits", d, 32'h0000_010B);
    wr(ca(3, 0), 32'h0000_0101);
    wr(ca(2, 2), 32'hDEAD_BEEF); rd(ca(2, 2), d); check("R10 phase store", d, 32'hDEAD_BEEF);
    wr(ca(1, 3), 32'h0005_0007); rd(ca(1, 3), d); check("R2 duty width", d, 32'h0000_0007);
    wr(8'h04, 32'h1234_5678);    rd(8'h04, d);    check("R2 unmapped", d, 32'h0);
  endtask

  task automatic t_staging;
    int hi;
    wr(ca(1, 1), 32'd4); wr(ca(1, 3), 32'd2); wr(8'h00, 32'h2);
    count_hi(1, 20, hi); check("R3 staged only", hi, 0);
  endtask

  task automatic t_basic;
    int hi;
    wr(ca(0, 1), 32'd10); wr(ca(0, 3), 32'd3);
    wr(8'h00, 32'h8000_0001);
    check("R5 not yet loaded", {31'd0, pwm_out[0]}, 32'd0);
    @(negedge clk);
    check("R5 idle load next edge", {31'd0, pwm_out[0]}, 32'd1);
    count_hi(0, 30, hi); check("R6 period 10 duty 3", hi, 9);
  endtask

  task automatic t_mid;
    int hi, guard;
    logic prev;
    logic [31:0] d;
    wr(ca(0, 3), 32'd5); wr(8'h00, 32'h8000_0001); idle(25);
    wr(ca(0, 3), 32'd2);
    count_hi(0, 30, hi); check("R3 duty staged not applied", hi, 15);
    guard = 0;
    prev = pwm_out[0];
    @(negedge clk);
    while (!(pwm_out[0] && !prev) && guard < 50) begin
      prev = pwm_out[0]; @(negedge clk); guard++;
    end
    wr(8'h00, 32'h8000_0001);
    rd(8'h00, d); check("R9 pending visible", d, 32'h8000_0001);
    count_hi(0, 8, hi);  check("R4 old duty to period end", hi, 3);
    count_hi(0, 10, hi); check("R4 new duty next period", hi, 2);
    rd(8'h00, d); check("R9 pending self-clears", d, 32'h0000_0001);
  endtask

  task automatic t_indep;
    int h0, h1;
    wr(ca(1, 1), 32'd4); wr(ca(1, 3), 32'd1);
    wr(8'h00, 32'h8000_0003); idle(20);
    fork
      count_hi(0, 40, h0);
      count_hi(1, 40, h1);
    join
    check("R11 ch0 own period", h0, 8);
    check("R11 ch1 own period", h1, 10);
  endtask

  task automatic t_bounds;
    int hi;
    wr(ca(2, 1), 32'd6); wr(ca(2, 3), 32'd9);
    wr(8'h00, 32'h8000_0007); idle(20);
    count_hi(2, 12, hi); check("R7 duty above period", hi, 12);
    wr(ca(2, 3), 32'd0); wr(8'h00, 32'h8000_0007); idle(20);
    count_hi(2, 12, hi); check("R7 duty zero", hi, 0);
    wr(ca(2, 1), 32'd0); wr(ca(2, 3), 32'd5); wr(8'h00, 32'h8000_0007); idle(20);
    count_hi(2, 12, hi); check("R7 period zero", hi, 0);
  endtask

  task automatic t_polarity;
    int hi;
    wr(ca(3, 0), 32'h109); wr(ca(3, 1), 32'd8); wr(ca(3, 3), 32'd2);
    wr(8'h00, 32'h8000_000F); idle(20);
    count_hi(3, 16, hi); check("R8 inverted waveform", hi, 12);
    wr(8'h00, 32'h8000_0007); idle(20);
    count_hi(3, 10, hi); check("R8 disabled inverted idles high", hi, 10);
  endtask

  task automatic t_phase_mode;
    int hi;
    logic [31:0] d;
    wr(ca(0, 2), 32'd5); wr(ca(0, 0), 32'h102);
    wr(8'h00, 32'h8000_0007); idle(20);
    count_hi(0, 20, hi); check("R10 phase and mode no effect", hi, 4);
    rd(ca(0, 0), d); check("R10 mode readback", d, 32'h102);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_regs;
    t_staging;
    t_basic;
    t_mid;
    t_indep;
    t_bounds;
    t_polarity;
    t_phase_mode;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule